// File: doc/BRIEF.md
# Video Timing Mode Classifier

This block watches the separated horizontal and vertical sync pulses of a host computer's video output and times them against the master clock (nominally 21.477 MHz). It works out which of eight raster modes is present. The modes come from two line lengths (1365 or 1368 clocks) crossed with four field structures: 313 or 312.5 lines at 50 Hz, and 262 or 262.5 lines at 60 Hz. It reports the mode as a 3-bit code with a valid flag. It also gives an output-format select for a display back-end, a field-parity bit for weaving interlaced fields, and a one-cycle pulse each time a classification is committed.

Both sync inputs pass through synchronizer flops before edge detection. The time between horizontal sync rising edges gives each line's length. Each field is measured from one vertical sync rising edge to the next: the block counts its lines and notes where within the line the vertical edge lands. A vertical edge that lands near mid-line on every other field marks interlaced scan. A classification is committed only when two consecutive fields agree. Any timing outside the accepted windows withdraws the valid flag. All nominal counts and tolerances are parameters, so the block can be scaled.

Top module: `vtm_classifier`

## Requirements
- R1: While reset is high and on the first cycle after it, mode_code is 0 and mode_valid, fmt_576, field_odd and mode_chg are all 0.
- R2: Lines are classified by their hsync-to-hsync period. Let SPLIT = (LINE_SHORT+LINE_LONG+1)/2. A period in [LINE_SHORT-LINE_TOL, SPLIT-1] is a short line, which sets mode_code bit 0 to 1. A period in [SPLIT, LINE_LONG+LINE_TOL] is a long line, which sets bit 0 to 0. A field whose lines are of mixed classes is rejected.
- R3: A line period outside both windows clears mode_valid. The flag falls within 6 cycles of the input hsync edge that ends that line.
- R4: Each field's line count is taken between vertical sync rising edges. A count within 1 of LINES_50 sets mode_code bit 2 to 1 (50 Hz). A count within 1 of LINES_60 sets bit 2 to 0 (60 Hz). Any other count rejects the field. A rejected field clears mode_valid.
- R5: A vertical sync edge is at mid-line when the time since the last hsync edge is within MID_TOL of (LINE_SHORT+LINE_LONG)/4. When the phase at a field's closing edge differs from the phase at its opening edge, mode_code bit 1 is 1 (interlaced). When the two phases are equal, bit 1 is 0.
- R6: field_odd is 1 exactly while the current field began with a mid-line vertical sync edge.
- R7: A classification is committed only at the end of the second of two consecutive accepted fields with equal codes. A single field never changes mode_code or sets mode_valid.
- R8: A commit happens when the agreed code differs from mode_code or when mode_valid is 0. mode_chg is high for exactly one cycle per commit and never at any other time.
- R9: fmt_576 is 1 (576-line 50 Hz format) when mode_valid is 1 and the mode is 50 Hz. It is 0 (640x480 60 Hz format) otherwise.
- R10: A commit shows on the outputs within 8 cycles of the input vertical sync rising edge that closes the second agreeing field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Separated horizontal sync, active high |
| vsync_in | input | 1 | Separated vertical sync, active high |
| mode_code | output | 3 | Committed mode {is_50hz, is_interlaced, is_short_line} |
| mode_valid | output | 1 | Committed mode reflects the current timing |
| fmt_576 | output | 1 | Output format select: 1 for 576-line 50 Hz, 0 for 640x480 60 Hz |
| field_odd | output | 1 | Current field began with a mid-line vertical sync |
| mode_chg | output | 1 | One-cycle pulse on each commit |

## Verification
Suppose the line-period window boundaries were wrong. The stream would then be classified with the wrong line-length bit, or marked bad and reported invalid. Either fault shows on mode_code or mode_valid one field after the faulty lines. A lost or stale field phase flips the interlace bit and field_odd at the next vertical edge. A broken agreement history shows as a commit one field too early, a missing mode_chg, or an unexpected one. The scoreboard sees each of these within a handful of cycles of the vertical edge that should or should not have committed.

// File: rtl/vtm_pkg.sv
package vtm_pkg;

    typedef struct packed {
        logic rate50;
        logic intl;
        logic shortl;
    } vmode_t;

    function automatic logic in_win(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/vtm_sync_edge.sv
module vtm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= sh[STAGES-1];
    end

    assign rise = sh[STAGES-1] & ~last;
endmodule

// File: rtl/vtm_line_meter.sv
module vtm_line_meter import vtm_pkg::*; #(
    parameter int LINE_LONG  = 1368,
    parameter int LINE_SHORT = 1365,
    parameter int LINE_TOL   = 2,
    parameter int HCNT_W     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_rise,
    output logic [HCNT_W-1:0] hcnt,
    output logic              line_done,
    output logic              line_ok,
    output logic              line_short
);
    localparam int SPLIT = (LINE_SHORT + LINE_LONG + 1) / 2;

    logic          have_line;
    logic [HCNT_W:0] period;
    logic          short_hit, long_hit;

    assign period    = {1'b0, hcnt} + 1'b1;
    assign short_hit = in_win(32'(period), LINE_SHORT - LINE_TOL, SPLIT - 1);
    assign long_hit  = in_win(32'(period), SPLIT, LINE_LONG + LINE_TOL);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt       <= '0;
            have_line  <= 1'b0;
            line_done  <= 1'b0;
            line_ok    <= 1'b0;
            line_short <= 1'b0;
        end else begin
            line_done <= 1'b0;
            if (hs_rise) begin
                hcnt      <= '0;
                have_line <= 1'b1;
                if (have_line) begin
                    line_done  <= 1'b1;
                    line_ok    <= short_hit | long_hit;
                    line_short <= short_hit;
                end
            end else if (hcnt != '1) begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vtm_field_meter.sv
module vtm_field_meter import vtm_pkg::*; #(
    parameter int LINES_50 = 313,
    parameter int LINES_60 = 262,
    parameter int HALF     = 683,
    parameter int MID_TOL  = 8,
    parameter int HCNT_W   = 12,
    parameter int LCNT_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_rise,
    input  logic              vs_rise,
    input  logic [HCNT_W-1:0] hcnt,
    input  logic              line_done,
    input  logic              line_ok,
    input  logic              line_short,
    output logic              fld_done,
    output logic              fld_good,
    output vmode_t            fld_sig,
    output logic              phase_mid
);
    logic              started, bad, cls_set, cls_short;
    logic [LCNT_W-1:0] lcnt, lcnt_nx;
    logic              bad_nx, cls_set_nx, cls_short_nx;
    logic              mid_now, is50, is60;
    vmode_t            sig_nx;

    always_comb begin
        lcnt_nx      = (hs_rise && lcnt != '1) ? lcnt + 1'b1 : lcnt;
        bad_nx       = bad | (line_done & (~line_ok | (cls_set & (line_short != cls_short))));
        cls_set_nx   = cls_set | (line_done & line_ok);
        cls_short_nx = cls_set ? cls_short : line_short;
        mid_now      = in_win(32'(hcnt), HALF - MID_TOL, HALF + MID_TOL);
        is50         = in_win(32'(lcnt_nx), LINES_50 - 1, LINES_50 + 1);
        is60         = in_win(32'(lcnt_nx), LINES_60 - 1, LINES_60 + 1);
        sig_nx.rate50 = is50;
        sig_nx.intl   = mid_now ^ phase_mid;
        sig_nx.shortl = cls_short_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started   <= 1'b0;
            bad       <= 1'b0;
            cls_set   <= 1'b0;
            cls_short <= 1'b0;
            lcnt      <= '0;
            fld_done  <= 1'b0;
            fld_good  <= 1'b0;
            fld_sig   <= '0;
            phase_mid <= 1'b0;
        end else begin
            fld_done <= 1'b0;
            if (vs_rise) begin
                started   <= 1'b1;
                phase_mid <= mid_now;
                fld_done  <= started;
                fld_good  <= started & ~bad_nx & cls_set_nx & (is50 | is60);
                fld_sig   <= sig_nx;
                lcnt      <= '0;
                bad       <= 1'b0;
                cls_set   <= 1'b0;
                cls_short <= 1'b0;
            end else begin
                lcnt      <= lcnt_nx;
                bad       <= bad_nx;
                cls_set   <= cls_set_nx;
                cls_short <= cls_short_nx;
            end
        end
    end
endmodule

// File: rtl/vtm_classifier.sv
module vtm_classifier import vtm_pkg::*; #(
    parameter int LINE_LONG   = 1368,
    parameter int LINE_SHORT  = 1365,
    parameter int LINE_TOL    = 2,
    parameter int LINES_50    = 313,
    parameter int LINES_60    = 262,
    parameter int MID_TOL     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync_in,
    input  logic       vsync_in,
    output logic [2:0] mode_code,
    output logic       mode_valid,
    output logic       fmt_576,
    output logic       field_odd,
    output logic       mode_chg
);
    localparam int HALF   = (LINE_SHORT + LINE_LONG) / 4;
    localparam int HCNT_W = $clog2(LINE_LONG + LINE_TOL + 1) + 1;
    localparam int LCNT_W = $clog2(LINES_50 + 2) + 1;

    logic              hs_rise, vs_rise;
    logic [HCNT_W-1:0] hcnt;
    logic              line_done, line_ok, line_short;
    logic              fld_done, fld_good, phase_mid;
    vmode_t            fld_sig;

    vmode_t            mode_q, prev_sig;
    logic              valid_q, chg_q, prev_good;

    vtm_sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
        .clk(clk), .rst(rst), .din(hsync_in), .rise(hs_rise));
    vtm_sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
        .clk(clk), .rst(rst), .din(vsync_in), .rise(vs_rise));

    vtm_line_meter #(
        .LINE_LONG(LINE_LONG), .LINE_SHORT(LINE_SHORT),
        .LINE_TOL(LINE_TOL), .HCNT_W(HCNT_W)
    ) u_line (
        .clk(clk), .rst(rst), .hs_rise(hs_rise), .hcnt(hcnt),
        .line_done(line_done), .line_ok(line_ok), .line_short(line_short));

    vtm_field_meter #(
        .LINES_50(LINES_50), .LINES_60(LINES_60), .HALF(HALF),
        .MID_TOL(MID_TOL), .HCNT_W(HCNT_W), .LCNT_W(LCNT_W)
    ) u_field (
        .clk(clk), .rst(rst), .hs_rise(hs_rise), .vs_rise(vs_rise),
        .hcnt(hcnt), .line_done(line_done), .line_ok(line_ok),
        .line_short(line_short), .fld_done(fld_done), .fld_good(fld_good),
        .fld_sig(fld_sig), .phase_mid(phase_mid));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            valid_q   <= 1'b0;
            chg_q     <= 1'b0;
            prev_good <= 1'b0;
            prev_sig  <= '0;
        end else begin
            chg_q <= 1'b0;
            if (line_done && !line_ok) valid_q <= 1'b0;
            if (fld_done) begin
                prev_good <= fld_good;
                prev_sig  <= fld_sig;
                if (!fld_good) begin
                    valid_q <= 1'b0;
                end else if (prev_good && fld_sig == prev_sig &&
                             (!valid_q || fld_sig != mode_q)) begin
                    mode_q  <= fld_sig;
                    valid_q <= 1'b1;
                    chg_q   <= 1'b1;
                end
            end
        end
    end

    assign mode_code  = mode_q;
    assign mode_valid = valid_q;
    assign mode_chg   = chg_q;
    assign fmt_576    = valid_q & mode_q.rate50;
    assign field_odd  = phase_mid;
endmodule

// File: rtl/vtm_checker.sv
module vtm_checker (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_code,
    input logic       mode_valid,
    input logic       mode_chg,
    input logic       line_done,
    input logic       line_ok
);
    assert_chg_single_R8: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> !mode_chg);

    assert_chg_with_valid_R8: assert property (@(posedge clk) disable iff (rst)
        mode_chg |-> mode_valid);

    assert_valid_rise_commit_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_valid) |-> mode_chg);

    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !mode_chg |-> $stable(mode_code));

    assert_bad_line_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (line_done && !line_ok) |=> !mode_valid);
endmodule

bind vtm_classifier vtm_checker chk_i (
    .clk(clk), .rst(rst), .mode_code(mode_code), .mode_valid(mode_valid),
    .mode_chg(mode_chg), .line_done(line_done), .line_ok(line_ok));

// File: tb/vtm_classifier_tb_top.sv
module vtm_classifier_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       hsync_in, vsync_in;
    logic [2:0] mode_code;
    logic       mode_valid, fmt_576, field_odd, mode_chg;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int vs_cyc = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vtm_classifier #(
        .LINE_LONG(40), .LINE_SHORT(37), .LINE_TOL(2),
        .LINES_50(13), .LINES_60(10), .MID_TOL(2), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .mode_code(mode_code), .mode_valid(mode_valid), .fmt_576(fmt_576),
        .field_odd(field_odd), .mode_chg(mode_chg));

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One field: n lines of len clocks, vertical edge in line 0 at start or mid-line
    task automatic gen_field(input int len, input int n, input bit mid);
        int off;
        off = mid ? 20 : 2;
        for (int i = 0; i < n; i++) begin
            for (int c = 0; c < len; c++) begin
                @(negedge clk);
                hsync_in = (c < 3);
                vsync_in = (i == 0) && (c >= off) && (c < off + 4);
                if (i == 0 && c == off) vs_cyc = cyc;
            end
        end
    endtask

    // Scoreboard monitor: every commit pulse must match the oldest expected code
    always @(negedge clk) begin
        if (!rst && mode_chg) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected mode_chg", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk("R8 committed mode_code", int'(mode_code), e);
                chk("R8 valid at commit", int'(mode_valid), 1);
                chk("R9 fmt_576 at commit", int'(fmt_576), (e >> 2) & 1);
                chk("R10 commit latency within 8", int'((cyc - vs_cyc) <= 8), 1);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; hsync_in = 1'b0; vsync_in = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mode_code", int'(mode_code), 0);
        chk("R1 mode_valid", int'(mode_valid), 0);
        chk("R1 fmt_576", int'(fmt_576), 0);
        chk("R1 field_odd", int'(field_odd), 0);
        chk("R1 mode_chg", int'(mode_chg), 0);

        // 60 Hz progressive, long lines at upper edge (42)
        gen_field(42, 10, 0);
        gen_field(42, 10, 0);
        chk("R7 single field no commit", int'(mode_valid), 0);
        exp_q.push_back(0);
        gen_field(42, 10, 0);
        chk("R2 long line code", int'(mode_code), 0);
        chk("R8 valid after commit", int'(mode_valid), 1);
        chk("R9 60 Hz format", int'(fmt_576), 0);
        chk("R6 progressive parity", int'(field_odd), 0);
        gen_field(42, 10, 0);

        // 50 Hz progressive, long lines at split (39)
        gen_field(39, 13, 0);
        gen_field(39, 13, 0);
        chk("R7 old mode held", int'(mode_code), 0);
        chk("R7 old mode still valid", int'(mode_valid), 1);
        exp_q.push_back(4);
        gen_field(39, 13, 0);
        chk("R4 50 Hz code", int'(mode_code), 4);
        chk("R9 576 format", int'(fmt_576), 1);

        // 50 Hz interlaced, short lines (38)
        gen_field(38, 13, 1);
        gen_field(38, 13, 0);
        exp_q.push_back(7);
        gen_field(38, 13, 1);
        chk("R5 interlaced 50 Hz code", int'(mode_code), 7);
        chk("R6 mid-line field odd", int'(field_odd), 1);
        gen_field(38, 13, 0);
        chk("R6 start-line field even", int'(field_odd), 0);
        chk("R5 code held", int'(mode_code), 7);

        // 60 Hz interlaced, short lines (37)
        gen_field(37, 10, 1);
        gen_field(37, 10, 0);
        exp_q.push_back(3);
        gen_field(37, 10, 1);
        chk("R5 interlaced 60 Hz code", int'(mode_code), 3);
        chk("R9 60 Hz format", int'(fmt_576), 0);
        gen_field(37, 10, 0);

        // Out-of-window line length (43)
        gen_field(43, 10, 0);
        chk("R3 bad line clears valid", int'(mode_valid), 0);
        chk("R9 format off when invalid", int'(fmt_576), 0);

        // Recovery with short lines at lower edge (35)
        gen_field(35, 10, 0);
        gen_field(35, 10, 0);
        chk("R7 one good field not enough", int'(mode_valid), 0);
        exp_q.push_back(1);
        gen_field(35, 10, 0);
        chk("R2 short line code", int'(mode_code), 1);
        chk("R2 valid after recovery", int'(mode_valid), 1);

        // Out-of-range line count
        gen_field(35, 7, 0);
        gen_field(35, 7, 0);
        chk("R4 bad line count clears valid", int'(mode_valid), 0);
        gen_field(35, 7, 0);

        // Same code recommitted after invalid
        gen_field(35, 10, 0);
        gen_field(35, 10, 0);
        exp_q.push_back(1);
        gen_field(35, 10, 0);
        chk("R8 recommit same code", int'(mode_code), 1);
        chk("R8 valid after recommit", int'(mode_valid), 1);

        repeat (20) @(negedge clk);
        chk("R8 all expected commits seen", exp_q.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule